// File: doc/BRIEF.md
# Operand Bypass and Interlock Control

This unit holds the hazard decisions of a five-stage in-order integer pipeline. The stages, in order, are fetch, decode, execute, memory and writeback. The unit watches three things: the two source register numbers of the instruction in decode, the two source register numbers of the instruction in execute, and the destination, write flag and load flag of the older instructions further down the pipe. From these it produces three kinds of output. The first is a per-operand select for the multiplexer in front of each ALU input. The second is a stall request that freezes the program counter and the fetch/decode register. The third is a bubble request that turns the decode/execute register into a no-op.

The unit is purely combinational and carries no stream traffic, so every pin is a plain control level and no valid/ready rules apply. A build-time parameter `BYPASS_EN` picks one of two variants. With bypassing, only a load followed at once by a consumer costs a cycle. Without bypassing, the select stays on the register file and the interlock alone covers every read-after-write distance. The register file writes in the first half of a cycle and reads in the second, so a writer in writeback never needs a bypass to decode.

Top module: `hz_unit`

## Requirements
- R1: With bypassing, an execute operand whose register number equals the destination of the memory-stage instruction gets select 2'b10, provided that instruction writes (write flag 1) and the destination is not register 0.
- R2: With bypassing, an execute operand that matches a writing writeback-stage destination other than register 0, and does not match the memory stage, gets select 2'b01. With no match the select is 2'b00, meaning the register file.
- R3: When both the memory-stage and writeback-stage destinations match an operand, the select is 2'b10, so the younger result wins.
- R4: Register 0 never causes a bypass or a stall, whether it appears as a source or as a destination.
- R5: A producer whose write flag is 0 never causes a bypass or a stall.
- R6: A writing instruction in writeback never causes a stall in either variant.
- R7: With bypassing, a load in execute (write flag 1, load flag 1) whose destination matches either decode source raises stall. A non-load in execute never raises stall.
- R8: With bypassing, a load-use pair costs exactly one stall cycle. Once the load has moved to the memory stage behind a bubble, the stall drops, and the consumer then takes the load result through select 2'b01.
- R9: Without bypassing, both selects are always 2'b00.
- R10: Without bypassing, a decode source that matches a writing execute-stage or memory-stage destination raises stall, so a load-use pair costs two stall cycles.
- R11: In both variants, bubble equals stall in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs1 | input | 5 | First source register of the instruction in decode |
| id_rs2 | input | 5 | Second source register of the instruction in decode |
| ex_rs1 | input | 5 | First source register of the instruction in execute |
| ex_rs2 | input | 5 | Second source register of the instruction in execute |
| ex_rd | input | 5 | Destination of the instruction in execute |
| ex_we | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | 5 | Destination of the instruction in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | 5 | Destination of the instruction in writeback |
| wb_we | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Select for ALU operand A: 00 register file, 10 memory-stage result, 01 writeback result |
| fwd_b | output | 2 | Select for ALU operand B, same encoding |
| stall | output | 1 | Freeze the program counter and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
A bypass select for the instruction in execute and a load-use stall for the instruction in decode can both fire in the same cycle. This happens when an ALU result in the memory stage feeds the execute operand while a load in execute targets a decode source. The bench builds exactly that pattern and checks that the select reads 2'b10 while stall and bubble are both high. It also replays a load-use sequence cycle by cycle on a bypassing instance and on a non-bypassing instance, and counts one stall cycle against two.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NUM_OPER = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] rd,
  input  logic          we,
  output logic          hit
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  assign hit = we && (rd != ZERO_REG) && (rd == src);
endmodule

// File: rtl/hz_bypass_sel.sv
module hz_bypass_sel #(
  parameter int AW        = 5,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic [AW-1:0]    src,
  input  logic [AW-1:0]    mem_rd,
  input  logic             mem_we,
  input  logic [AW-1:0]    wb_rd,
  input  logic             wb_we,
  output hz_pkg::fwd_sel_e sel
);
  import hz_pkg::*;

  generate
    if (BYPASS_EN) begin : g_bypass
      logic mem_hit;
      logic wb_hit;

      hz_match #(.AW(AW)) u_mem (.src(src), .rd(mem_rd), .we(mem_we), .hit(mem_hit));
      hz_match #(.AW(AW)) u_wb  (.src(src), .rd(wb_rd),  .we(wb_we),  .hit(wb_hit));

      // younger producer takes priority
      always_comb begin
        if (mem_hit)     sel = FWD_MEM;
        else if (wb_hit) sel = FWD_WB;
        else             sel = FWD_RF;
      end

      always_comb begin
        if (mem_hit && wb_hit)
          a_r3_younger_wins: assert (sel == FWD_MEM) else $error("older result selected");
        if (src == '0)
          a_r4_zero_src_rf: assert (sel == FWD_RF) else $error("register 0 bypassed");
        if (!mem_we && !wb_we)
          a_r5_no_writer_rf: assert (sel == FWD_RF) else $error("bypass without writer");
      end
    end else begin : g_rf_only
      logic unused_in;
      assign unused_in = ^{src, mem_rd, mem_we, wb_rd, wb_we};
      assign sel = FWD_RF;
    end
  endgenerate
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int AW        = 5,
  parameter int NSRC      = 2,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic [NSRC-1:0][AW-1:0] id_src,
  input  logic [AW-1:0]           ex_rd,
  input  logic                    ex_we,
  input  logic                    ex_load,
  input  logic [AW-1:0]           mem_rd,
  input  logic                    mem_we,
  output logic                    hold
);
  logic [NSRC-1:0] need;

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      logic ex_hit;
      hz_match #(.AW(AW)) u_ex (.src(id_src[g]), .rd(ex_rd), .we(ex_we), .hit(ex_hit));

      if (BYPASS_EN) begin : g_load_only
        // only a load in execute cannot be bypassed in time
        assign need[g] = ex_hit && ex_load;
      end else begin : g_full
        logic mem_hit;
        hz_match #(.AW(AW)) u_mem (.src(id_src[g]), .rd(mem_rd), .we(mem_we), .hit(mem_hit));
        // writeback needs nothing: split-cycle register file
        assign need[g] = ex_hit || mem_hit;
      end
    end
  endgenerate

  assign hold = |need;

  always_comb begin
    if (!ex_we && !mem_we)
      a_r5_no_writer_no_hold: assert (!hold) else $error("hold without writer");
    if (id_src == '0)
      a_r4_zero_src_no_hold: assert (!hold) else $error("hold on register 0");
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
  parameter int AW        = 5,
  parameter bit BYPASS_EN = 1'b1
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          bubble
);
  import hz_pkg::*;

  localparam int NOP = NUM_OPER;

  logic [NOP-1:0][AW-1:0] id_src;
  logic [NOP-1:0][AW-1:0] ex_src;
  fwd_sel_e               sel [NOP];
  logic                   hold;

  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;
  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  generate
    for (genvar k = 0; k < NOP; k++) begin : g_oper
      hz_bypass_sel #(.AW(AW), .BYPASS_EN(BYPASS_EN)) u_sel (
        .src    (ex_src[k]),
        .mem_rd (mem_rd),
        .mem_we (mem_we),
        .wb_rd  (wb_rd),
        .wb_we  (wb_we),
        .sel    (sel[k])
      );
    end
  endgenerate

  hz_interlock #(.AW(AW), .NSRC(NOP), .BYPASS_EN(BYPASS_EN)) u_lock (
    .id_src  (id_src),
    .ex_rd   (ex_rd),
    .ex_we   (ex_we),
    .ex_load (ex_load),
    .mem_rd  (mem_rd),
    .mem_we  (mem_we),
    .hold    (hold)
  );

  assign fwd_a  = sel[0];
  assign fwd_b  = sel[1];
  assign stall  = hold;
  assign bubble = hold;

  generate
    if (BYPASS_EN) begin : g_chk
      always_comb begin
        if (!ex_load)
          a_r7_alu_no_stall: assert (!stall) else $error("stall on ALU producer");
      end
    end
  endgenerate
endmodule

// File: tb/tb_hz_unit.sv
`timescale 1ns/1ps
module tb_hz_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic ex_we = 1'b0, ex_load = 1'b0, mem_we = 1'b0, wb_we = 1'b0;

  logic [1:0] fwd_a, fwd_b, nb_fwd_a, nb_fwd_b;
  logic stall, bubble, nb_stall, nb_bubble;

  hz_unit #(.AW(AW), .BYPASS_EN(1'b1)) dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble));

  hz_unit #(.AW(AW), .BYPASS_EN(1'b0)) dut_nb (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .fwd_a(nb_fwd_a), .fwd_b(nb_fwd_b), .stall(nb_stall), .bubble(nb_bubble));

  typedef struct {
    logic [1:0] fa;
    logic [1:0] fb;
    logic       st;
    logic       nb_st;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: apply one pipeline snapshot and queue what the requirements predict
  task automatic step(input logic [AW-1:0] i1, i2, e1, e2, erd,
                      input logic ewe, eld,
                      input logic [AW-1:0] mrd, input logic mwe,
                      input logic [AW-1:0] wrd, input logic wwe,
                      input logic [1:0] fa, fb, input logic st, nbst,
                      input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2;
    ex_rd = erd; ex_we = ewe; ex_load = eld;
    mem_rd = mrd; mem_we = mwe; wb_rd = wrd; wb_we = wwe;
    e.fa = fa; e.fb = fb; e.st = st; e.nb_st = nbst; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " fwd_a"}, int'(fwd_a), int'(e.fa));
      check({e.tag, " fwd_b"}, int'(fwd_b), int'(e.fb));
      check({e.tag, " stall"}, int'(stall), int'(e.st));
      check({e.tag, " nobypass stall"}, int'(nb_stall), int'(e.nb_st));
      check("R9 nobypass fwd_a", int'(nb_fwd_a), 0);
      check("R9 nobypass fwd_b", int'(nb_fwd_b), 0);
      check("R11 bubble", int'(bubble), int'(stall));
      check("R11 nobypass bubble", int'(nb_bubble), int'(nb_stall));
    end
  end

  initial begin
    // idle pipeline
    step(0,0, 0,0, 0,0,0, 0,0, 0,0, 2'b00,2'b00, 0,0, "R5 idle");
    // memory-stage result to operand A, then operand B
    step(0,0, 3,0, 0,0,0, 3,1, 0,0, 2'b10,2'b00, 0,0, "R1 opA");
    step(0,0, 0,7, 0,0,0, 7,1, 0,0, 2'b00,2'b10, 0,0, "R1 opB");
    // writeback result to operand A; writeback never stalls decode
    step(4,0, 4,0, 0,0,0, 0,0, 4,1, 2'b01,2'b00, 0,0, "R2/R6 wb");
    // both stages match: younger wins
    step(0,0, 9,9, 0,0,0, 9,1, 9,1, 2'b10,2'b10, 0,0, "R3 both");
    // distinct sources from distinct stages
    step(0,0, 5,6, 0,0,0, 6,1, 5,1, 2'b01,2'b10, 0,0, "R1/R2 split");
    // register 0 everywhere
    step(0,0, 0,0, 0,1,1, 0,1, 0,1, 2'b00,2'b00, 0,0, "R4 zero");
    // matches with write flags low
    step(8,8, 8,8, 8,0,1, 8,0, 8,0, 2'b00,2'b00, 0,0, "R5 no write");
    // load-use on either decode source
    step(2,0, 0,0, 2,1,1, 0,0, 0,0, 2'b00,2'b00, 1,1, "R7/R10 load rs1");
    step(0,11, 0,0, 11,1,1, 0,0, 0,0, 2'b00,2'b00, 1,1, "R7/R10 load rs2");
    // ALU producer in execute: no stall with bypass, stall without
    step(2,0, 0,0, 2,1,0, 0,0, 0,0, 2'b00,2'b00, 0,1, "R7/R10 alu");
    // memory-stage producer only stalls without bypass
    step(13,0, 0,0, 0,0,0, 13,1, 0,0, 2'b00,2'b00, 0,1, "R10 mem");
    // load-use sequence: load in EX, then in MEM behind bubble, then in WB
    step(6,0, 0,0, 6,1,1, 0,0, 0,0, 2'b00,2'b00, 1,1, "R8 seq c1");
    step(6,0, 0,0, 0,0,0, 6,1, 0,0, 2'b00,2'b00, 0,1, "R8/R10 seq c2");
    step(6,0, 6,0, 0,0,0, 0,0, 6,1, 2'b01,2'b00, 0,0, "R8/R6 seq c3");
    // bypass select and load-use stall in the same cycle
    step(0,12, 3,0, 12,1,1, 3,1, 0,0, 2'b10,2'b00, 1,1, "R1/R7 concurrent");
    // dependent chain: consumer in EX sees producer in MEM, next in WB
    step(1,0, 1,0, 4,1,0, 1,1, 0,0, 2'b10,2'b00, 0,1, "R1 chain c1");
    step(1,0, 1,0, 6,1,0, 4,1, 1,1, 2'b01,2'b00, 0,0, "R2 chain c2");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule